// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches a byte-wide receive stream, one frame at a time, and decides whether to keep each frame. It looks at the first six bytes (the destination address) and compares them against a programmed 48-bit station address and against the all-ones broadcast address. Three control bits steer the decision: broadcast reject, promiscuous mode and drop-while-transmitting. Alongside the address check it counts the bytes of the frame and compares the count with a maximum length register. That register resets to 1518 and can be rewritten at run time.

When the last byte of a frame has arrived, the filter pulses a done strobe for one cycle. In that same cycle it presents three status flags: accept, miss (kept only because of promiscuous mode, or a broadcast kept despite broadcast reject) and too-long. A separate one-cycle babble interrupt fires as soon as the running count first passes the maximum. The stream sink never applies back-pressure. `s_ready` is held high, so every cycle with `s_valid` high transfers a byte, and a source may insert idle cycles (valid low) anywhere inside a frame. A static configuration check flags internal loopback combined with drop-while-transmitting.

Top module: `rx_accept_filter`

## Requirements
- R1: With promiscuous mode sampled set and the frame not dropped, done comes with accept high whatever the destination address.
- R2: With broadcast reject set and promiscuous mode clear, a frame whose first six bytes are all 0xFF completes with accept low.
- R3: With broadcast reject and promiscuous mode both set, a broadcast frame completes with accept high and miss high.
- R4: With promiscuous mode clear, accept is high exactly when the six destination bytes, first byte first, equal `cfg_station[47:0]` most significant byte first, or when the frame is broadcast and broadcast reject is clear; frames shorter than six bytes match nothing; miss stays low.
- R5: In promiscuous mode a frame matching neither station nor broadcast completes with miss high; a station match completes with miss low; miss is never high without accept.
- R6: The maximum length register resets to 1518; a cycle with `cfg_max_we` high loads `cfg_max_len`, and the new value applies from the next start of frame.
- R7: The length counts every transferred byte from the start-of-frame byte through the end-of-frame byte; too-long is high at done when that count is strictly greater than the maximum.
- R8: `babble_irq` is high for exactly one cycle, the cycle after the byte that makes the count first exceed the maximum, at most once per frame.
- R9: When drop-while-transmitting and `tx_active` are both high at start of frame, the frame completes with accept, miss and too-long low and raises no babble; with drop-while-transmitting clear, `tx_active` has no effect.
- R10: The control bits, `tx_active` and the maximum are sampled on the start-of-frame byte and changes during the frame do not affect that frame.
- R11: done is high for one cycle, the cycle after the end-of-frame byte; while done is low the three status flags are low.
- R12: `cfg_illegal` is high exactly when `cfg_loopback` and `cfg_drop_on_tx` are both high.
- R13: Bytes arriving outside a frame without start-of-frame are ignored; a start-of-frame byte inside a frame restarts it; `s_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bcast_reject | input | 1 | Reject broadcast destination |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_drop_on_tx | input | 1 | Drop frames starting while transmitting |
| cfg_loopback | input | 1 | Internal loopback selected (checked only) |
| cfg_station | input | 48 | Station address, first byte in bits 47:40 |
| cfg_max_we | input | 1 | Load maximum length |
| cfg_max_len | input | 16 | New maximum length in bytes |
| tx_active | input | 1 | Local transmitter busy |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Always high |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| done | output | 1 | Frame status valid |
| st_accept | output | 1 | Frame accepted |
| st_miss | output | 1 | Accepted without address match |
| st_too_long | output | 1 | Frame exceeded maximum |
| babble_irq | output | 1 | One-cycle over-length pulse |
| cfg_illegal | output | 1 | Loopback with drop-while-transmitting |

## Verification
Done and the three status flags are due one clock after the edge that takes the end-of-frame byte. The babble pulse is due one clock after the edge that takes the byte that first passes the maximum. `cfg_illegal` follows its inputs in the same cycle. The bench drives inputs on the falling edge, and a behavioural model steps on the rising edge from those inputs. Every output is compared with the model three nanoseconds after each rising edge, so both sides have settled on the same cycle's values. Maximum-length writes, control changes in mid-frame and resets are applied at falling edges so that the sampling rule of R10 is exercised.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  typedef struct packed {
    logic bc_reject;
    logic promisc;
    logic drop_on_tx;
    logic tx_busy;
  } rx_ctl_t;

  typedef struct packed {
    logic accept;
    logic miss;
    logic too_long;
  } rx_status_t;
endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         beat,
  input  logic                         sof,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station,
  output logic                         da_station,
  output logic                         da_bcast
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic [IDX_W-1:0]  idx_q, idx_base, idx_n;
  logic              sta_q, bc_q, sta_base, bc_base, sta_n, bc_n;
  logic [BYTE_W-1:0] sta_byte;

  always_comb begin
    idx_base = sof ? '0 : idx_q;
    sta_base = sof ? 1'b1 : sta_q;
    bc_base  = sof ? 1'b1 : bc_q;
    sta_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_base == IDX_W'(k))
        sta_byte = station[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W];
    if (idx_base < IDX_W'(ADDR_BYTES)) begin
      idx_n = idx_base + 1'b1;
      sta_n = sta_base && (data == sta_byte);
      bc_n  = bc_base && (&data);
    end else begin
      idx_n = idx_base;
      sta_n = sta_base;
      bc_n  = bc_base;
    end
  end

  // Result including the current byte; meaningful on a beat.
  assign da_station = (idx_n == IDX_W'(ADDR_BYTES)) && sta_n;
  assign da_bcast   = (idx_n == IDX_W'(ADDR_BYTES)) && bc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sta_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (beat) begin
      idx_q <= idx_n;
      sta_q <= sta_n;
      bc_q  <= bc_n;
    end
  end
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [LEN_W-1:0] limit,
  output logic             over_n,
  output logic             first_over
);
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             was_over;

  always_comb begin
    if (sof)         cnt_n = LEN_W'(1);
    else if (&cnt_q) cnt_n = cnt_q;          // saturate
    else             cnt_n = cnt_q + 1'b1;
    over_n     = cnt_n > limit;
    was_over   = !sof && (cnt_q > limit);
    first_over = over_n && !was_over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/rx_accept_rules.sv
module rx_accept_rules
  import rx_filt_pkg::*;
(
  input  rx_ctl_t    ctl,
  input  logic       da_station,
  input  logic       da_bcast,
  input  logic       over,
  output logic       blocked,
  output rx_status_t status
);
  always_comb begin
    blocked = ctl.drop_on_tx && ctl.tx_busy;
    status  = '0;
    if (!blocked) begin
      status.too_long = over;
      if (ctl.promisc) begin
        status.accept = 1'b1;
        status.miss   = (da_bcast && ctl.bc_reject) || (!da_station && !da_bcast);
      end else begin
        status.accept = da_station || (da_bcast && !ctl.bc_reject);
      end
    end
  end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES    = 6,
  parameter int LEN_W         = 16,
  parameter int MAX_LEN_RESET = 1518
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_bcast_reject,
  input  logic                    cfg_promisc,
  input  logic                    cfg_drop_on_tx,
  input  logic                    cfg_loopback,
  input  logic [ADDR_BYTES*8-1:0] cfg_station,
  input  logic                    cfg_max_we,
  input  logic [LEN_W-1:0]        cfg_max_len,
  input  logic                    tx_active,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_sof,
  input  logic                    s_eof,
  output logic                    done,
  output logic                    st_accept,
  output logic                    st_miss,
  output logic                    st_too_long,
  output logic                    babble_irq,
  output logic                    cfg_illegal
);
  rx_ctl_t    ctl_live, ctl_q, ctl_eff;
  rx_status_t status;
  logic [LEN_W-1:0] max_q, max_lat_q, lim_eff;
  logic in_frame_q, beat, blocked, da_station, da_bcast, over_n, first_over;

  assign s_ready     = 1'b1;
  assign cfg_illegal = cfg_loopback && cfg_drop_on_tx;   // R12
  assign beat        = s_valid && (s_sof || in_frame_q); // R13

  always_comb begin
    ctl_live = '{bc_reject: cfg_bcast_reject, promisc: cfg_promisc,
                 drop_on_tx: cfg_drop_on_tx, tx_busy: tx_active};
    ctl_eff  = s_sof ? ctl_live : ctl_q;                 // R10
    lim_eff  = s_sof ? max_q : max_lat_q;
  end

  rx_addr_match #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(8)) u_addr (
    .clk, .rst_n, .beat, .sof(s_sof), .data(s_data), .station(cfg_station),
    .da_station, .da_bcast
  );

  rx_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk, .rst_n, .beat, .sof(s_sof), .limit(lim_eff), .over_n, .first_over
  );

  rx_accept_rules u_rules (
    .ctl(ctl_eff), .da_station, .da_bcast, .over(over_n), .blocked, .status
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      ctl_q       <= '0;
      max_q       <= LEN_W'(MAX_LEN_RESET);
      max_lat_q   <= LEN_W'(MAX_LEN_RESET);
      done        <= 1'b0;
      st_accept   <= 1'b0;
      st_miss     <= 1'b0;
      st_too_long <= 1'b0;
      babble_irq  <= 1'b0;
    end else begin
      if (cfg_max_we) max_q <= cfg_max_len;             // R6
      if (beat) begin
        in_frame_q <= !s_eof;
        if (s_sof) begin
          ctl_q     <= ctl_live;
          max_lat_q <= max_q;
        end
      end
      done        <= beat && s_eof;                     // R11
      st_accept   <= beat && s_eof && status.accept;
      st_miss     <= beat && s_eof && status.miss;
      st_too_long <= beat && s_eof && status.too_long;  // R7
      babble_irq  <= beat && first_over && !blocked;    // R8
    end
  end
endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_sof,
  input logic s_eof,
  input logic beat,
  input logic blocked,
  input logic done,
  input logic st_accept,
  input logic st_miss,
  input logic st_too_long,
  input logic babble_irq
);
  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(st_accept || st_miss || st_too_long));

  p_done_follows_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat && s_eof));

  p_miss_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |-> st_accept);

  p_babble_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    babble_irq && !(s_valid && s_sof) |=> !babble_irq);

  p_blocked_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(blocked) |-> !st_accept && !st_miss && !st_too_long);
endmodule

bind rx_accept_filter rx_accept_filter_chk u_chk (.*);

// File: tb/test_rx_accept_filter.sv
module test_rx_accept_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bcast_reject = 0, cfg_promisc = 0, cfg_drop_on_tx = 0, cfg_loopback = 0;
  logic [47:0] cfg_station = 48'h02_11_22_33_44_55;
  logic cfg_max_we = 0;
  logic [15:0] cfg_max_len = '0;
  logic tx_active = 0, s_valid = 0, s_sof = 0, s_eof = 0;
  logic [7:0] s_data = '0;
  logic s_ready, done, st_accept, st_miss, st_too_long, babble_irq, cfg_illegal;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_accept_filter i_rx_accept_filter (
    .clk, .rst_n, .cfg_bcast_reject, .cfg_promisc, .cfg_drop_on_tx, .cfg_loopback,
    .cfg_station, .cfg_max_we, .cfg_max_len, .tx_active, .s_valid, .s_ready,
    .s_data, .s_sof, .s_eof, .done, .st_accept, .st_miss, .st_too_long,
    .babble_irq, .cfg_illegal
  );

  // ---------------- behavioural reference ----------------
  bit e_done, e_acc, e_miss, e_tl, e_bab;
  int m_reg, m_lat, len;
  bit in_f, l_bcrej, l_prom, l_blk, babbled;
  byte unsigned da[6];

  always @(posedge clk) begin
    if (!rst_n) begin
      {e_done, e_acc, e_miss, e_tl, e_bab} = '0;
      m_reg = 1518; m_lat = 1518; in_f = 0; len = 0;
    end else begin
      {e_done, e_acc, e_miss, e_tl, e_bab} = '0;
      if (s_valid && (s_sof || in_f)) begin
        if (s_sof) begin
          len = 0; in_f = 1; babbled = 0; m_lat = m_reg;
          l_bcrej = cfg_bcast_reject; l_prom = cfg_promisc;
          l_blk = cfg_drop_on_tx && tx_active;
        end
        if (len < 6) da[len] = s_data;
        len++;
        if (len > m_lat && !babbled && !l_blk) begin e_bab = 1; babbled = 1; end
        if (s_eof) begin
          bit sta, bc;
          sta = len >= 6; bc = len >= 6;
          for (int k = 0; k < 6; k++) begin
            if (da[k] != cfg_station[8*(5-k) +: 8]) sta = 0;
            if (da[k] != 8'hFF) bc = 0;
          end
          e_done = 1; in_f = 0;
          if (!l_blk) begin
            e_tl = len > m_lat;
            if (l_prom) begin
              e_acc = 1; e_miss = (bc && l_bcrej) || (!sta && !bc);
            end else e_acc = sta || (bc && !l_bcrej);
          end
        end
      end
      if (cfg_max_we) m_reg = cfg_max_len;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #3;
    if (rst_n && !finished) begin
      chk(done, e_done, "R11", "done");
      chk(st_accept, e_acc, "R4", "accept");
      chk(st_miss, e_miss, "R5", "miss");
      chk(st_too_long, e_tl, "R7", "too_long");
      chk(babble_irq, e_bab, "R8", "babble");
      chk(cfg_illegal, cfg_loopback && cfg_drop_on_tx, "R12", "illegal");
      chk(s_ready, 1'b1, "R13", "ready");
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic [7:0] d, input bit sof, input bit eof);
    @(negedge clk);
    s_valid = 1; s_data = d; s_sof = sof; s_eof = eof;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [47:0] dst, input int total, input bit gaps, input bit flip);
    for (int i = 0; i < total; i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk); s_valid = 0;
      end
      drive((i < 6) ? dst[8*(5-i) +: 8] : 8'(i), i == 0, i == total - 1);
      if (flip && i == 1) begin
        cfg_promisc = ~cfg_promisc; tx_active = ~tx_active;
      end
    end
    idle(2);
  endtask

  task automatic set_max(input int v);
    @(negedge clk); cfg_max_we = 1; cfg_max_len = 16'(v);
    @(negedge clk); cfg_max_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    // R11: reset state
    chk(done || st_accept || st_miss || st_too_long || babble_irq, 1'b0, "R11", "reset outputs");
    rst_n = 1;
  endtask

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTH = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    chk(done, 1'b0, "R11", "done in reset");
    rst_n = 1;
    idle(2);
    // R4 station match / mismatch / short frame
    send(STA, 20, 0, 0);
    send(OTH, 20, 1, 0);
    send(STA, 4, 0, 0);
    // R4 broadcast kept, R2 broadcast rejected
    send(BC, 12, 0, 0);
    cfg_bcast_reject = 1;
    send(BC, 12, 0, 0);
    send(STA, 12, 0, 0);
    // R1 R3 R5 promiscuous
    cfg_promisc = 1;
    send(BC, 12, 0, 0);
    send(OTH, 12, 1, 0);
    send(STA, 12, 0, 0);
    cfg_bcast_reject = 0;
    send(BC, 12, 0, 0);
    send(STA, 3, 0, 0);
    cfg_promisc = 0;
    // R7 R8 strict length bound with small maximum (R6 write)
    set_max(10);
    send(STA, 10, 0, 0);
    send(STA, 11, 0, 0);
    send(OTH, 25, 1, 0);
    // R6 mid-frame write applies at next start
    fork
      send(STA, 20, 0, 0);
      begin repeat (4) @(negedge clk); cfg_max_we = 1; cfg_max_len = 30;
            @(negedge clk); cfg_max_we = 0; end
    join
    send(STA, 20, 0, 0);
    // R9 drop while transmitting, and independence when disabled
    set_max(8);
    cfg_drop_on_tx = 1; tx_active = 1;
    send(STA, 15, 0, 0);
    cfg_drop_on_tx = 0;
    send(STA, 15, 0, 0);
    tx_active = 0;
    // R10 controls change mid-frame
    send(OTH, 12, 0, 1);
    send(OTH, 12, 0, 1);
    cfg_drop_on_tx = 1;
    send(STA, 12, 0, 1);
    send(STA, 12, 0, 1);
    cfg_drop_on_tx = 0; tx_active = 0; cfg_promisc = 0;
    // R12 illegal combination
    cfg_loopback = 1; idle(2);
    cfg_drop_on_tx = 1; idle(2);
    cfg_loopback = 0; cfg_drop_on_tx = 0; idle(1);
    // R13 stray bytes, restart, single-byte frame, back-to-back
    drive(8'hAA, 0, 0); drive(8'hBB, 0, 1); idle(2);
    drive(8'h02, 1, 0); drive(8'h11, 0, 0);
    send(STA, 9, 0, 0);
    set_max(0);
    drive(8'hFF, 1, 1); drive(8'hFF, 1, 1); idle(2);
    set_max(100);
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 8; i++)
        drive((i < 6) ? STA[8*(5-i) +: 8] : 8'h00, i == 0, i == 7);
    idle(3);
    // R6 reset value 1518
    do_reset();
    idle(2);
    send(STA, 1518, 0, 0);
    send(STA, 1519, 0, 0);
    idle(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule